// File: doc/BRIEF.md
# Peripheral Request Router

This block sits between a large group of peripheral DMA request lines and a much smaller set of DMA channels. Each request line owns a routing entry: a channel number plus an enable bit. Software programs these entries over a 32-bit register bus. Every enabled request line is steered onto its chosen channel. When several lines point at the same channel, that channel sees the OR of all of them.

The router keeps a registered copy of each channel's request level. It exports this level so a transfer engine can pace on it, and so a status read can show that a request is pending. Whenever the level of a channel changes, the router sends a one-cycle event toward the channel status logic. A rise produces a request-after-stop set pulse. A fall produces an end-of-receive set pulse together with a request-after-stop clear pulse. A write that enables a route toward a channel number above the configured channel count raises a configuration error pulse.

The routing entries occupy two address windows. Three request-status word addresses read as zero and discard writes.

Top module: `dma_req_router`

## Requirements
- R1: After reset every routing entry reads as zero. A read of an entry returns the channel number in bits [4:0] and the enable bit in bit 7. All other bits read zero, whatever was written to them.
- R2: Entry n for n below 64 sits at byte address 0x100 + 4n. Entry n from 64 up to NUM_REQ-1 sits at 0x1100 + 4(n-64). A write at one entry's address changes no other entry.
- R3: Reads at addresses 0xE0, 0xE4 and 0xE8 return zero. Writes there change no routing entry.
- R4: A routing write with bit 7 set and a channel field strictly greater than NUM_CH raises cfg_err for exactly the following cycle. Any other write leaves cfg_err low. The written value is stored in either case.
- R5: ch_req[c] equals the OR of every request input whose entry is enabled with channel number c, as sampled at the previous clock edge. It is zero after reset.
- R6: A request input whose entry has the enable bit clear, or whose channel number is NUM_CH or above, has no effect on ch_req or on any event output.
- R7: When a channel's request goes from inactive to active, ras_set[c] pulses for one cycle, in the same cycle that ch_req[c] rises.
- R8: When a channel's request goes from active to inactive, eor_set[c] and ras_clr[c] pulse together for one cycle, in the same cycle that ch_req[c] falls.
- R9: While a channel's request level holds steady, no event pulses on that channel. This holds even when the inputs that feed it change, for example one of two OR'd inputs dropping while the other stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | NUM_REQ | Peripheral request levels, synchronous to clk |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe; zero otherwise |
| cfg_err | output | 1 | One-cycle pulse flagging an out-of-range routing write |
| ch_req | output | NUM_CH | Registered per-channel request level |
| ras_set | output | NUM_CH | Request-after-stop set pulse per channel |
| ras_clr | output | NUM_CH | Request-after-stop clear pulse per channel |
| eor_set | output | NUM_CH | End-of-receive set pulse per channel |

## Verification
The assertions rely on two input properties:
- Request inputs change only between clock edges.
- A bus access presents address, strobe and data together for a single cycle, so a registered error pulse can be traced to the write one cycle earlier.

The stimulus drives every input at the falling edge and holds each access for exactly one cycle. Each request burst stays up for two edges, so every rise and fall lands at a distinct, predictable edge. The edge checks compare each pulse with the change in the exported level, and do not assume anything about how the level was formed. Remapping an entry while its input is high is therefore legal stimulus for the assertions, although the sweeps avoid it.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

  // Field layout of a routing entry as seen on the bus
  localparam int CH_FIELD_W = 5;
  localparam int EN_BIT     = 7;

  // Address windows of the routing entries
  localparam int LO_BASE = 32'h0100;
  localparam int HI_BASE = 32'h1100;
  localparam int LO_SPAN = 64;

  // Request-status words: read as zero, writes dropped
  localparam logic [15:0] STAT_A0 = 16'h00E0;
  localparam logic [15:0] STAT_A1 = 16'h00E4;
  localparam logic [15:0] STAT_A2 = 16'h00E8;

  typedef struct packed {
    logic                  en;
    logic [CH_FIELD_W-1:0] chan;
  } route_ent_t;

  function automatic route_ent_t unpack_entry(input logic [31:0] d);
    route_ent_t e;
    e.en   = d[EN_BIT];
    e.chan = d[CH_FIELD_W-1:0];
    return e;
  endfunction

  function automatic logic [31:0] pack_entry(input route_ent_t e);
    logic [31:0] d;
    d = '0;
    d[EN_BIT] = e.en;
    d[CH_FIELD_W-1:0] = e.chan;
    return d;
  endfunction

  // True when the address selects an existing routing entry
  function automatic logic entry_hit(input logic [15:0] a, input int num_req);
    int ai;
    ai = int'(a);
    if (a[1:0] != 2'b00) return 1'b0;
    if (ai >= LO_BASE && ai < LO_BASE + 4 * LO_SPAN && ((ai - LO_BASE) >> 2) < num_req)
      return 1'b1;
    if (ai >= HI_BASE && ai < HI_BASE + 4 * (num_req - LO_SPAN))
      return 1'b1;
    return 1'b0;
  endfunction

  // Entry number selected by an address (meaningful only when entry_hit)
  function automatic int entry_index(input logic [15:0] a);
    int ai;
    ai = int'(a);
    if (ai >= HI_BASE) return LO_SPAN + ((ai - HI_BASE) >> 2);
    return (ai - LO_BASE) >> 2;
  endfunction

  function automatic logic is_status_word(input logic [15:0] a);
    return (a == STAT_A0) || (a == STAT_A1) || (a == STAT_A2);
  endfunction

  // Enabled route pointing above the configured channel count
  function automatic logic route_over(input route_ent_t e, input int num_ch);
    return e.en && (int'(e.chan) > num_ch);
  endfunction

endpackage

// File: rtl/dmr_route_regs.sv
module dmr_route_regs
  import dmr_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [15:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        cfg_err,
  output logic        wr_hit,
  output route_ent_t  ent_q [NUM_REQ]
);

  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic             acc_hit;
  logic [IDX_W-1:0] acc_idx;
  route_ent_t       wr_ent;

  assign acc_hit = entry_hit(bus_addr, NUM_REQ);
  assign acc_idx = IDX_W'(entry_index(bus_addr));
  assign wr_ent  = unpack_entry(bus_wdata);
  assign wr_hit  = bus_sel && bus_wr && acc_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NUM_REQ; r++) ent_q[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REQ; r++) begin
        if (wr_hit && acc_idx == IDX_W'(r)) ent_q[r] <= wr_ent;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= wr_hit && route_over(wr_ent, NUM_CH);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && acc_hit) bus_rdata = pack_entry(ent_q[acc_idx]);
  end

endmodule

// File: rtl/dmr_merge.sv
module dmr_merge
  import dmr_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  route_ent_t         ent_q [NUM_REQ],
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_CH-1:0]  ch_now
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_comb begin
      logic acc;
      acc = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (ent_q[r].en && ent_q[r].chan == CH_FIELD_W'(c)) acc = acc | req_in[r];
      end
      ch_now[c] = acc;
    end
  end

endmodule

// File: rtl/dmr_edge.sv
module dmr_edge #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_now,
  output logic [NUM_CH-1:0] ch_lvl,
  output logic [NUM_CH-1:0] rise_p,
  output logic [NUM_CH-1:0] fall_p
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_det
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_lvl[c] <= 1'b0;
        rise_p[c] <= 1'b0;
        fall_p[c] <= 1'b0;
      end else begin
        ch_lvl[c] <= ch_now[c];
        rise_p[c] <= ch_now[c] && !ch_lvl[c];
        fall_p[c] <= !ch_now[c] && ch_lvl[c];
      end
    end
  end

endmodule

// File: rtl/dma_req_router.sv
module dma_req_router
  import dmr_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [15:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               cfg_err,
  output logic [NUM_CH-1:0]  ch_req,
  output logic [NUM_CH-1:0]  ras_set,
  output logic [NUM_CH-1:0]  ras_clr,
  output logic [NUM_CH-1:0]  eor_set
);

  route_ent_t          ent_q [NUM_REQ];
  logic                wr_hit;
  logic [NUM_CH-1:0]   ch_now;
  logic [NUM_CH-1:0]   rise_p;
  logic [NUM_CH-1:0]   fall_p;

  dmr_route_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_err(cfg_err), .wr_hit(wr_hit), .ent_q(ent_q)
  );

  dmr_merge #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_merge (
    .ent_q(ent_q), .req_in(req_in), .ch_now(ch_now)
  );

  dmr_edge #(.NUM_CH(NUM_CH)) u_edge (
    .clk(clk), .rst(rst), .ch_now(ch_now),
    .ch_lvl(ch_req), .rise_p(rise_p), .fall_p(fall_p)
  );

  assign ras_set = rise_p;
  assign ras_clr = fall_p;
  assign eor_set = fall_p;

endmodule

// File: rtl/dmr_checker.sv
module dmr_checker
  import dmr_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] req_in,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [15:0]        bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               cfg_err,
  input logic [NUM_CH-1:0]  ch_req,
  input logic [NUM_CH-1:0]  ras_set,
  input logic [NUM_CH-1:0]  ras_clr,
  input logic [NUM_CH-1:0]  eor_set
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_RISE_ON_UP: assert property (@(posedge clk) disable iff (rst)
      ras_set[c] |-> (ch_req[c] && !$past(ch_req[c]))); // R7
    AST_EOR_ON_DOWN: assert property (@(posedge clk) disable iff (rst)
      eor_set[c] |-> (!ch_req[c] && $past(ch_req[c]))); // R8
    AST_CLR_ON_DOWN: assert property (@(posedge clk) disable iff (rst)
      ras_clr[c] |-> (!ch_req[c] && $past(ch_req[c]))); // R8
    AST_LEVEL_CHANGE_EVENT: assert property (@(posedge clk) disable iff (rst)
      !$stable(ch_req[c]) |-> (ras_set[c] || eor_set[c])); // R7
    AST_QUIET_STEADY: assert property (@(posedge clk) disable iff (rst)
      $stable(ch_req[c]) |-> (!ras_set[c] && !eor_set[c] && !ras_clr[c])); // R9
  end

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(bus_sel && bus_wr && bus_wdata[EN_BIT] &&
                      (int'(bus_wdata[CH_FIELD_W-1:0]) > NUM_CH))); // R4
  AST_IDLE_INPUTS: assert property (@(posedge clk) disable iff (rst)
    $past(req_in == '0) |-> (ch_req == '0)); // R5

  always_comb begin
    if (!rst && bus_sel && !bus_wr && is_status_word(bus_addr))
      AST_STATUS_ZERO: assert (bus_rdata == 32'h0); // R3
  end

endmodule

bind dma_req_router dmr_checker #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .req_in(req_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cfg_err(cfg_err), .ch_req(ch_req), .ras_set(ras_set), .ras_clr(ras_clr),
  .eor_set(eor_set)
);

// File: tb/sim_dma_req_router.sv
`timescale 1ns/1ps
module sim_dma_req_router;
  localparam int NR = 75;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NR-1:0] req_in = '0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          cfg_err;
  logic [NC-1:0] ch_req, ras_set, ras_clr, eor_set;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  dma_req_router #(.NUM_REQ(NR), .NUM_CH(NC)) u0 (
    .clk(clk), .rst(rst), .req_in(req_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_err(cfg_err), .ch_req(ch_req), .ras_set(ras_set), .ras_clr(ras_clr),
    .eor_set(eor_set)
  );

  always #2 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] addr_of(input int n);
    if (n < 64) return 16'(256 + n * 4);
    return 16'(4352 + (n - 64) * 4);
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ev_chk(input string req, input logic [NC-1:0] lvl, input logic [NC-1:0] rs, input logic [NC-1:0] fl);
    logic ok;
    ok = (ch_req == lvl) && (ras_set == rs) && (eor_set == fl) && (ras_clr == fl);
    chk(ok, req, {8'(ch_req), 8'(ras_set), 8'(eor_set), 8'(ras_clr)}, {8'(lvl), 8'(rs), 8'(fl), 8'(fl)});
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog R1..all actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R5: reset state
    ev_chk("R5 reset levels", '0, '0, '0);
    chk(cfg_err == 1'b0, "R4 reset err", 32'(cfg_err), 0);
    for (int n = 0; n < NR; n++) begin
      rd(addr_of(n), d);
      chk(d == 0, "R1 reset entry", d, 0);
    end

    // R1 / R2: sweep all entries with junk in unused bits
    for (int n = 0; n < NR; n++) wr(addr_of(n), 32'hFFFF_FF60 | 32'((n * 7) % 32) | ((n % 2) << 7));
    for (int n = 0; n < NR; n++) begin
      rd(addr_of(n), d);
      chk(d == (32'((n * 7) % 32) | 32'((n % 2) << 7)), "R1 R2 entry readback", d,
          32'((n * 7) % 32) | 32'((n % 2) << 7));
    end

    // R3: status words read zero and leave entries untouched
    wr(16'h00E0, 32'hFFFF_FFFF); wr(16'h00E4, 32'hFFFF_FFFF); wr(16'h00E8, 32'hFFFF_FFFF);
    rd(16'h00E0, d); chk(d == 0, "R3 status0", d, 0);
    rd(16'h00E4, d); chk(d == 0, "R3 status1", d, 0);
    rd(16'h00E8, d); chk(d == 0, "R3 status2", d, 0);
    for (int n = 0; n < NR; n++) begin
      rd(addr_of(n), d);
      chk(d == (32'((n * 7) % 32) | 32'((n % 2) << 7)), "R3 entries intact", d,
          32'((n * 7) % 32) | 32'((n % 2) << 7));
    end

    // R4: error boundary
    wr(addr_of(3), 32'h89);  chk(cfg_err == 1'b1, "R4 chan 9 enabled", 32'(cfg_err), 1);
    @(negedge clk);          chk(cfg_err == 1'b0, "R4 one-cycle pulse", 32'(cfg_err), 0);
    rd(addr_of(3), d);       chk(d == 32'h89, "R4 stored anyway", d, 32'h89);
    wr(addr_of(4), 32'h88);  chk(cfg_err == 1'b0, "R4 chan equal count", 32'(cfg_err), 0);
    wr(addr_of(70), 32'h1F); chk(cfg_err == 1'b0, "R4 disabled high chan", 32'(cfg_err), 0);
    wr(addr_of(74), 32'h9F); chk(cfg_err == 1'b1, "R4 chan 31 enabled", 32'(cfg_err), 1);

    // R5 R7 R8: each input alone, routed to n%NC
    for (int n = 0; n < NR; n++) wr(addr_of(n), 32'h80 | 32'(n % NC));
    for (int n = 0; n < NR; n++) begin
      logic [NC-1:0] m;
      m = NC'(1) << (n % NC);
      @(negedge clk); req_in[n] = 1'b1;
      @(negedge clk); ev_chk("R5 R7 rise", m, m, '0);
      @(negedge clk); ev_chk("R7 single pulse", m, '0, '0);
      req_in[n] = 1'b0;
      @(negedge clk); ev_chk("R8 fall", '0, '0, m);
      @(negedge clk); ev_chk("R8 single pulse", '0, '0, '0);
    end

    // R6: disabled entry, channel equal to count, channel above count
    wr(addr_of(5), 32'h05);
    wr(addr_of(6), 32'h88);
    wr(addr_of(7), 32'h8C);
    @(negedge clk); req_in[5] = 1'b1; req_in[6] = 1'b1; req_in[7] = 1'b1;
    @(negedge clk); ev_chk("R6 ignored rise", '0, '0, '0);
    req_in[5] = 1'b0; req_in[6] = 1'b0; req_in[7] = 1'b0;
    @(negedge clk); ev_chk("R6 ignored fall", '0, '0, '0);

    // R9: two inputs OR'd on channel 3
    wr(addr_of(10), 32'h83);
    wr(addr_of(70), 32'h83);
    @(negedge clk); req_in[10] = 1'b1;
    @(negedge clk); ev_chk("R5 R7 or first", 8'h08, 8'h08, '0);
    req_in[70] = 1'b1;
    @(negedge clk); ev_chk("R9 second joins", 8'h08, '0, '0);
    req_in[10] = 1'b0;
    @(negedge clk); ev_chk("R9 first leaves", 8'h08, '0, '0);
    req_in[70] = 1'b0;
    @(negedge clk); ev_chk("R8 last leaves", '0, '0, 8'h08);

    // R5: several channels at once
    @(negedge clk); req_in[0] = 1'b1; req_in[65] = 1'b1; req_in[74] = 1'b1;
    @(negedge clk); ev_chk("R5 multi rise", 8'h07, 8'h07, '0);
    req_in[65] = 1'b0;
    @(negedge clk); ev_chk("R8 partial fall", 8'h05, '0, 8'h02);
    req_in = '0;
    @(negedge clk); ev_chk("R8 rest fall", '0, '0, 8'h05);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule